// File: doc/BRIEF.md
# Load/Store Multiple Transfer Sequencer

This block moves a group of registers between a sixteen-entry register file and memory, one word per clock. A command gives a sixteen-bit list of registers, the index of the register that holds the base address, a load or store select, an up or down direction, a before-or-after address adjustment and a base update enable. The block reads the base, works out the first address and the updated base, then walks the listed registers from lowest index to highest at rising word addresses. It drives the register-file read and write ports and a simple memory bus.

Memory can refuse any single word by raising an abort input in the same cycle as the request. The block does not stop early. A store keeps running to the end. A load stops changing registers from the refused word onward and puts the base register back in a known state. In both cases a trap flag is raised together with the done pulse.

The base update lands at a fixed point in the sequence. As a result, the value stored for the base register depends on where it sits in the list.

Top module: `lsm_sequencer`

## Requirements
- R1: A command whose base index is 15 is refused. In the cycle after `start`, `done` and `illegal` are high. No memory request is made and no register is written.
- R2: A command with an empty register list makes no memory request and writes no register. It raises `done` in the cycle after `start`, with `illegal` low.
- R3: One word moves per cycle. Registers go in ascending index order and addresses rise by 4. The first address depends on the two selects, where B is the base value and N is the number of set bits in the list:
  - up with the adjustment before: B+4
  - up with the adjustment after: B
  - down with the adjustment before: B-4N
  - down with the adjustment after: B-4N+4
- R4: When base update is enabled, the base register receives B+4N (up) or B-4N (down) through the write port during the first transfer cycle. When it is disabled, the base register is never written by a store.
- R5: A store sends each listed register's value on `mem_wdata` with `mem_we` high. If the base is first in the list, its original value is stored. If the base comes later and base update is enabled, its updated value is stored.
- R6: A load writes each returned word into its register one cycle after its transfer. If the base is in the list, the loaded word replaces the updated base.
- R7: A refused store word does not stop the sequence. Every listed word is still requested. The only register change is the base update.
- R8: After a refused load word, neither that word nor any later word is written to a register. Earlier loaded words keep their effect.
- R9: After a refused load, the base register ends holding the updated base if update is enabled, and its original value otherwise. Register 15 is left unchanged.
- R10: `done` is a single-cycle pulse, raised one cycle after the last transfer. `abort_trap` is high with it exactly when some word was refused. After reset, `busy`, `done`, `mem_req` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a command when idle |
| reg_mask | input | 16 | Register list, bit i selects register i |
| base_sel | input | 4 | Index of the base register |
| op_load | input | 1 | 1 load, 0 store |
| dir_up | input | 1 | 1 ascending from base, 0 descending |
| idx_pre | input | 1 | Adjust address before the transfer |
| wb_en | input | 1 | Update the base register |
| busy | output | 1 | Command in progress |
| done | output | 1 | End-of-command pulse |
| illegal | output | 1 | With done: command refused for base 15 |
| abort_trap | output | 1 | With done: a word was refused |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, same cycle |
| mem_abort | input | 1 | Memory refuses this transfer |

## Verification
The sweep covers every base index, all sixteen mode combinations and lists where the base is first, second, alone or absent, plus the full list. An update landing one cycle late would store the old base from second position. An update landing early would store the new base from first position. Aborts are placed at the first word, a middle word and the last word. A design that kept writing after a refused load, or skipped the base restore, would leave the wrong final register file. Register 15 at the tail shows up as a changed program counter when the tail is aborted. A store that stopped early shows up as missing requests.

// File: rtl/lsm_pkg.sv
// Shared types for the load/store multiple sequencer.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package lsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_FINISH
    } lsm_state_t;

    typedef struct packed {
        logic load;
        logic up;
        logic pre;
        logic wb;
    } lsm_mode_t;

endpackage

// File: rtl/lsm_pick.sv
// Lowest-set-bit finder over the remaining register list.
// Assumes NREG is a power of two; idx is don't-care when any is low.
module lsm_pick #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    output logic [IW-1:0]   idx,
    output logic            any
);

    logic [NREG-1:0] lowest;

    // isolate the lowest set bit
    assign lowest = mask & (~mask + NREG'(1));
    assign any    = |mask;

    // encode the isolated bit into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (lowest[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/lsm_addr_gen.sv
// Computes the first transfer address and the updated base from the
// base value, the register list and the direction/adjust selects.
// Assumes word-sized transfers of WORD_BYTES bytes.
module lsm_addr_gen #(
    parameter int NREG       = 16,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic [DW-1:0]   base_val,
    input  logic [NREG-1:0] mask,
    input  logic            up,
    input  logic            pre,
    output logic [DW-1:0]   start_addr,
    output logic [DW-1:0]   wb_addr,
    output logic [CW-1:0]   count
);

    logic [DW-1:0] span;
    logic [DW-1:0] step;

    // count the listed registers
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) count = count + CW'(mask[i]);
    end

    assign step = DW'(WORD_BYTES);
    assign span = DW'(count) * step;

    // first address and updated base per direction and adjust mode
    always_comb begin
        if (up) begin
            wb_addr    = base_val + span;
            start_addr = pre ? base_val + step : base_val;
        end else begin
            wb_addr    = base_val - span;
            start_addr = pre ? base_val - span : base_val - span + step;
        end
    end

endmodule

// File: rtl/lsm_sequencer.sv
// Load/store multiple sequencer. Cycle 1 reads the base, cycle 2 is the
// first transfer and writes the updated base, loads commit one cycle
// after their transfer, and a final cycle flushes the last load or
// restores the base after a refused load, and pulses done.
// Assumes a register file with combinational read and clocked write,
// and a memory that answers (data or abort) in the request cycle.
module lsm_sequencer
    import lsm_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int IW     = $clog2(NREG),
    localparam int CW     = $clog2(NREG + 1),
    localparam int PC_IDX = NREG - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] reg_mask,
    input  logic [IW-1:0]   base_sel,
    input  logic            op_load,
    input  logic            dir_up,
    input  logic            idx_pre,
    input  logic            wb_en,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic            abort_trap,
    output logic [IW-1:0]   rf_raddr,
    input  logic [DW-1:0]   rf_rdata,
    output logic            rf_we,
    output logic [IW-1:0]   rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_abort
);

    lsm_state_t      st_q;
    lsm_mode_t       mode_q;
    logic [IW-1:0]   base_q;
    logic [NREG-1:0] left_q;
    logic [NREG-1:0] left_nx;
    logic [DW-1:0]   addr_q, wbval_q, orig_q;
    logic            first_q, aborted_q, ld_pend_q;
    logic [IW-1:0]   ld_idx_q;
    logic [DW-1:0]   ld_data_q;
    logic [IW-1:0]   cur_idx;
    logic            cur_any;
    logic [DW-1:0]   start_addr, wb_addr;
    logic [CW-1:0]   count;
    logic            base_is_pc, setup_reject;

    lsm_pick #(.NREG(NREG)) u_pick (
        .mask (left_q),
        .idx  (cur_idx),
        .any  (cur_any)
    );

    lsm_addr_gen #(.NREG(NREG), .DW(DW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .base_val   (rf_rdata),
        .mask       (left_q),
        .up         (mode_q.up),
        .pre        (mode_q.pre),
        .start_addr (start_addr),
        .wb_addr    (wb_addr),
        .count      (count)
    );

    // drop the register being moved this cycle from the list
    assign left_nx      = left_q & (left_q - NREG'(1));
    assign base_is_pc   = (base_q == IW'(PC_IDX));
    assign setup_reject = base_is_pc || (count == '0);

    // port drive per state
    always_comb begin
        busy       = (st_q != ST_IDLE);
        done       = 1'b0;
        illegal    = 1'b0;
        abort_trap = 1'b0;
        rf_raddr   = '0;
        rf_we      = 1'b0;
        rf_waddr   = base_q;
        rf_wdata   = wbval_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = addr_q;
        mem_wdata  = rf_rdata;
        case (st_q)
            ST_SETUP: begin
                rf_raddr = base_q;
                if (setup_reject) begin
                    done    = 1'b1;
                    illegal = base_is_pc;
                end
            end
            ST_XFER: begin
                rf_raddr = cur_idx;
                mem_req  = cur_any;
                mem_we   = ~mode_q.load;
                if (first_q && mode_q.wb) begin
                    rf_we = 1'b1;
                end else if (ld_pend_q) begin
                    rf_we    = 1'b1;
                    rf_waddr = ld_idx_q;
                    rf_wdata = ld_data_q;
                end
            end
            ST_FINISH: begin
                done       = 1'b1;
                abort_trap = aborted_q;
                if (mode_q.load && aborted_q) begin
                    rf_we    = 1'b1;
                    rf_wdata = mode_q.wb ? wbval_q : orig_q;
                end else if (ld_pend_q) begin
                    rf_we    = 1'b1;
                    rf_waddr = ld_idx_q;
                    rf_wdata = ld_data_q;
                end
            end
            default: ;
        endcase
    end

    // sequence state, addresses and pending load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            mode_q    <= '0;
            base_q    <= '0;
            left_q    <= '0;
            addr_q    <= '0;
            wbval_q   <= '0;
            orig_q    <= '0;
            first_q   <= 1'b0;
            aborted_q <= 1'b0;
            ld_pend_q <= 1'b0;
            ld_idx_q  <= '0;
            ld_data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= '{load: op_load, up: dir_up, pre: idx_pre, wb: wb_en};
                        base_q <= base_sel;
                        left_q <= reg_mask;
                        st_q   <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    aborted_q <= 1'b0;
                    ld_pend_q <= 1'b0;
                    first_q   <= 1'b1;
                    if (setup_reject) begin
                        st_q <= ST_IDLE;
                    end else begin
                        addr_q  <= start_addr;
                        wbval_q <= wb_addr;
                        orig_q  <= rf_rdata;
                        st_q    <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    first_q   <= 1'b0;
                    left_q    <= left_nx;
                    addr_q    <= addr_q + DW'(WORD_BYTES);
                    if (mem_abort) aborted_q <= 1'b1;
                    ld_pend_q <= mode_q.load & ~mem_abort & ~aborted_q;
                    ld_idx_q  <= cur_idx;
                    ld_data_q <= mem_rdata;
                    if (left_nx == '0) st_q <= ST_FINISH;
                end
                default: begin
                    ld_pend_q <= 1'b0;
                    st_q      <= ST_IDLE;
                end
            endcase
        end
    end

    assert_reject_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETUP && base_is_pc) |=> (st_q == ST_IDLE && !mem_req));

    assert_empty_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETUP && left_q == '0) |-> (done && !rf_we && !mem_req));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && $past(st_q) == ST_XFER)
            |-> (mem_addr == $past(mem_addr) + DW'(WORD_BYTES)));

    assert_wb_second_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && $past(st_q) == ST_SETUP && mode_q.wb)
            |-> (rf_we && rf_waddr == base_q));

    assert_store_runs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && !mode_q.load && mem_abort && left_nx != '0) |=> mem_req);

    assert_quiet_after_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && mode_q.load && aborted_q) |-> (st_q == ST_FINISH && rf_waddr == base_q));

    assert_pc_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == IW'(PC_IDX)) |-> !aborted_q);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_lsm_sequencer.sv
// Sweep bench: every base index, every mode, several list shapes and
// abort positions; expected addresses, data and final register file
// are computed arithmetically here.
module test_lsm_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] reg_mask = '0;
    logic [3:0]  base_sel = '0;
    logic        op_load = 1'b0, dir_up = 1'b0, idx_pre = 1'b0, wb_en = 1'b0;
    logic        busy, done, illegal, abort_trap;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we, mem_abort;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] rf [16];
    int          xk = 0;
    int          abort_at = 99;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0] ^ 16'hBEEF, a[15:0]};
    endfunction

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = memval(mem_addr);
    assign mem_abort = mem_req && (xk == abort_at);

    always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;
    always @(posedge clk) if (mem_req) xk <= xk + 1;

    lsm_sequencer i_lsm_sequencer (
        .clk, .rst_n, .start, .reg_mask, .base_sel, .op_load, .dir_up,
        .idx_pre, .wb_en, .busy, .done, .illegal, .abort_trap,
        .rf_raddr, .rf_rdata, .rf_we, .rf_waddr, .rf_wdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_abort
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [15:0] m, input int b, input bit ld,
                            input bit up, input bit pre, input bit wb, input int ab);
        logic [31:0] init [16];
        logic [31:0] expv [16];
        int          regs [16];
        int          n = 0;
        int          cyc;
        int          k = 0;
        bit          reject, saw_req = 0, saw_we = 0, trap_exp;
        logic [31:0] bval, wbv, sa;
        bval = 32'h0001_0000 + 32'(b) * 32'h100;
        for (int i = 0; i < 16; i++) begin
            init[i] = 32'hC0DE_0000 | 32'(i * 17);
            if (m[i]) begin regs[n] = i; n++; end
        end
        init[b] = bval;
        reject  = (b == 15) || (n == 0);
        wbv = up ? bval + 32'(4 * n) : bval - 32'(4 * n);
        if (up) sa = pre ? bval + 4 : bval;
        else    sa = pre ? bval - 32'(4 * n) : bval - 32'(4 * n) + 4;
        trap_exp = !reject && (ab < n);
        @(negedge clk);
        for (int i = 0; i < 16; i++) rf[i] = init[i];
        xk = 0; abort_at = ab;
        reg_mask = m; base_sel = 4'(b); op_load = ld; dir_up = up;
        idx_pre = pre; wb_en = wb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (1) begin
            if (mem_req) begin
                saw_req = 1;
                if (k < n) begin
                    check(mem_addr == sa + 32'(4 * k), "R3 address", mem_addr, sa + 32'(4 * k));
                    check(mem_we == !ld, "R5 direction", 32'(mem_we), 32'(!ld));
                    if (!ld) begin
                        logic [31:0] e;
                        e = (regs[k] == b && wb && k > 0) ? wbv : init[regs[k]];
                        check(mem_wdata == e, "R5 store data", mem_wdata, e);
                    end
                end
                k++;
            end
            if (rf_we) saw_we = 1;
            if (cyc == 2 && wb && !reject)
                check(rf_we && rf_waddr == 4'(b) && rf_wdata == wbv, "R4 base update cycle",
                      rf_wdata, wbv);
            if (done || cyc > 40) break;
            @(negedge clk);
            cyc++;
        end
        check(cyc == (reject ? 1 : n + 2), "R10 done timing", 32'(cyc), 32'(reject ? 1 : n + 2));
        check(abort_trap == trap_exp, ld ? "R10 trap flag" : "R7 trap flag",
              32'(abort_trap), 32'(trap_exp));
        check(illegal == (b == 15), "R1 illegal flag", 32'(illegal), 32'(b == 15));
        check(k == (reject ? 0 : n), ld ? "R3 transfer count" : "R7 transfer count",
              32'(k), 32'(reject ? 0 : n));
        if (reject) check(!saw_req && !saw_we, (b == 15) ? "R1 quiet" : "R2 quiet",
                          32'(saw_req | saw_we), 32'd0);
        for (int i = 0; i < 16; i++) expv[i] = init[i];
        if (!reject) begin
            if (wb) expv[b] = wbv;
            if (ld) begin
                int a;
                a = (ab < n) ? ab : n;
                for (int j = 0; j < a; j++) expv[regs[j]] = memval(sa + 32'(4 * j));
                if (ab < n) expv[b] = wb ? wbv : bval;
            end
        end
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            string tag;
            if (reject)                      tag = "R2 regs kept";
            else if (ld && ab < n && i == b) tag = "R9 base restore";
            else if (ld && ab < n && i == 15) tag = "R9 pc kept";
            else if (ld && ab < n)           tag = "R8 regs after abort";
            else if (ld)                     tag = "R6 loaded regs";
            else if (ab < n)                 tag = "R7 regs after store abort";
            else                             tag = "R4 regs after store";
            check(rf[i] == expv[i], tag, rf[i], expv[i]);
        end
    endtask

    initial begin
        #(8 * 195000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && !rf_we, "R10 reset state",
              {28'd0, busy, done, mem_req, rf_we}, 32'd0);
        rst_n = 1'b1;
        for (int b = 0; b < 16; b++) begin
            for (int md = 0; md < 16; md++) begin
                for (int p = 0; p < 5; p++) begin
                    logic [15:0] m;
                    int n;
                    case (p)
                        0: m = 16'(1 << b) | 16'h8000;
                        1: m = 16'(1 << b) | 16'h0001;
                        2: m = 16'hFFFF;
                        3: m = 16'(b * 16'h9E37) ^ 16'h5A3C;
                        default: m = 16'h0000;
                    endcase
                    n = $countones(m);
                    if (p == 4) begin
                        run_case(m, b, md[0], md[1], md[2], md[3], 99);
                    end else begin
                        run_case(m, b, md[0], md[1], md[2], md[3], 99);
                        run_case(m, b, md[0], md[1], md[2], md[3], 0);
                        run_case(m, b, md[0], md[1], md[2], md[3], n / 2);
                        run_case(m, b, md[0], md[1], md[2], md[3], n - 1);
                    end
                end
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule